// File: doc/BRIEF.md
# Debug Register-Write Command Decoder

This block sits after the byte receiver of a serial debug port. It watches a stream of bytes from a debug host and turns two kinds of write command into single-cycle write strobes toward the register files. The first kind writes a processor control register and is only honoured while the core is halted. The second kind writes a debug control register in any core state. For a short list of protected debug registers, the second kind may not alter the top byte of the register.

Every write command is one command byte followed by four operand bytes. The operand is always a full 32 bits, whatever width the target register really has. When a processor-register command arrives while the core is running, the decoder reports it as illegal. It still swallows the four operand bytes so that the stream stays in step. Any other command byte is dropped and consumes no operand bytes.

Top module: `dbgwr_decoder`

## Requirements
- R1: While idle, a byte whose two top bits are `11` (0xC0..0xFF) opens a processor-register write whose register number is the byte's low six bits. If `coreHalted` is high in the cycle that byte is taken, `cpuWrEn` pulses with `wrNum` equal to that number.
- R2: Each write command takes exactly the next four valid bytes as its operand, most significant byte first. `wrData` in the strobe cycle equals {byte1, byte2, byte3, byte4}.
- R3: A write strobe (`cpuWrEn` or `dbgWrEn`) is high for exactly the one cycle after the fourth operand byte is taken. `wrNum` and `wrData` are valid in that cycle. At most one of `cpuWrEn`, `dbgWrEn` and `illegalCmd` is high in any cycle.
- R4: A processor-register command taken while `coreHalted` is low raises `illegalCmd` for exactly the following cycle. It still consumes its four operand bytes and produces no write strobe.
- R5: The halted state is sampled only with the command byte. A change of `coreHalted` during the operand bytes does not change the outcome.
- R6: While idle, a byte whose two top bits are `10` (0x80..0xBF) opens a debug-register write with register number equal to its low six bits. It pulses `dbgWrEn` whatever the value of `coreHalted`.
- R7: During `dbgWrEn`, `dbgByteEn` bit k enables `wrData` bits 8k+7..8k. Protected register numbers (by default 0x00, 0x01 and 0x02) give `4'b0111`, so bits 31..24 are left unwritten. All other numbers give `4'b1111`.
- R8: While idle, a byte with top bit `0` (0x00..0x7F) is ignored. It consumes no operand bytes and causes no strobe or illegal flag.
- R9: A synchronous reset (`rst` high at a clock edge) drops any partial command and returns the decoder to waiting for a command byte. After reset, all strobes and the illegal flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byteValid | input | 1 | A host byte is present this cycle |
| byteData | input | 8 | Host byte |
| coreHalted | input | 1 | Core is halted |
| cpuWrEn | output | 1 | Processor control register write strobe |
| dbgWrEn | output | 1 | Debug control register write strobe |
| wrNum | output | 6 | Target register number |
| wrData | output | 32 | 32-bit write operand |
| dbgByteEn | output | 4 | Byte enables for the debug write |
| illegalCmd | output | 1 | One-cycle pulse: processor write attempted while running |

## Verification
On every cycle, the assertions check that:
- the strobes are one-cycle pulses and never overlap the illegal flag;
- a strobe only follows a taken byte;
- the illegal flag only follows a processor command seen while running;
- the register number stays fixed while operand bytes arrive.

Only the bench scenarios can show the rest: operand byte order, the protected byte-enable list, the halted sample being latched at the command byte, bytes outside both families being skipped without losing alignment, and recovery from a reset in the middle of a command.

// File: rtl/dbgwr_pkg.sv
package dbgwr_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_W     = 6;
  localparam int OPER_BYTES = 4;
  localparam int DATA_W    = BYTE_W * OPER_BYTES;
  localparam int CNT_W     = $clog2(OPER_BYTES);

  typedef enum logic [1:0] {
    FAM_NONE = 2'b00,
    FAM_CPU  = 2'b11,
    FAM_DBG  = 2'b10
  } family_e;

  typedef struct packed {
    logic captureCmd;
    logic shiftByte;
  } ctrlStrobes_t;
endpackage

// File: rtl/dbgwr_ctrl.sv
module dbgwr_ctrl
  import dbgwr_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         byteValid,
  input  logic [1:0]   cmdTop,
  input  logic         coreHalted,
  output ctrlStrobes_t strobes,
  output logic         cpuWrEn,
  output logic         dbgWrEn,
  output logic         illegalCmd
);
  typedef enum logic {ST_IDLE, ST_OPER} state_e;
  typedef enum logic [1:0] {K_DROP, K_CPU, K_DBG} kind_e;

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OPER_BYTES - 1);

  state_e           state;
  kind_e            kind;
  logic [CNT_W-1:0] byteCnt;
  logic             isCpuCmd, isDbgCmd;

  always_comb begin
    isCpuCmd = (state == ST_IDLE) && byteValid && (cmdTop == FAM_CPU);
    isDbgCmd = (state == ST_IDLE) && byteValid && (cmdTop == FAM_DBG);
    strobes.captureCmd = isCpuCmd || isDbgCmd;
    strobes.shiftByte  = (state == ST_OPER) && byteValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      kind       <= K_DROP;
      byteCnt    <= '0;
      cpuWrEn    <= 1'b0;
      dbgWrEn    <= 1'b0;
      illegalCmd <= 1'b0;
    end else begin
      cpuWrEn    <= 1'b0;
      dbgWrEn    <= 1'b0;
      illegalCmd <= 1'b0;
      case (state)
        ST_IDLE: begin
          byteCnt <= '0;
          if (isCpuCmd) begin
            state      <= ST_OPER;
            kind       <= coreHalted ? K_CPU : K_DROP;
            illegalCmd <= !coreHalted;
          end else if (isDbgCmd) begin
            state <= ST_OPER;
            kind  <= K_DBG;
          end
        end
        ST_OPER: begin
          if (byteValid) begin
            if (byteCnt == LAST_CNT) begin
              state   <= ST_IDLE;
              cpuWrEn <= (kind == K_CPU);
              dbgWrEn <= (kind == K_DBG);
            end else begin
              byteCnt <= byteCnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: illegal flag only after a processor command taken while running
  p_illegal_cause_r4: assert property (@(posedge clk) disable iff (rst)
    illegalCmd |-> $past(byteValid && cmdTop == FAM_CPU && !coreHalted));

  // R3: strobes are single-cycle pulses
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
    (cpuWrEn || dbgWrEn) |=> !(cpuWrEn || dbgWrEn));

  // R2: a strobe always follows an accepted operand byte
  p_strobe_after_byte_r2: assert property (@(posedge clk) disable iff (rst)
    (cpuWrEn || dbgWrEn) |-> $past(byteValid));

  // R3: the three result signals never overlap
  p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpuWrEn, dbgWrEn, illegalCmd}));
endmodule

// File: rtl/dbgwr_dpath.sv
module dbgwr_dpath
  import dbgwr_pkg::*;
#(
  parameter int NUM_PROT = 3,
  parameter logic [NUM_PROT*NUM_W-1:0] PROT_NUMS = {6'h02, 6'h01, 6'h00}
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strobes,
  input  logic [BYTE_W-1:0]   byteData,
  output logic [NUM_W-1:0]    wrNum,
  output logic [DATA_W-1:0]   wrData,
  output logic [OPER_BYTES-1:0] dbgByteEn
);
  logic [NUM_PROT-1:0] protHit;
  logic                protFlag;

  for (genvar i = 0; i < NUM_PROT; i++) begin : g_prot
    assign protHit[i] = (byteData[NUM_W-1:0] == PROT_NUMS[i*NUM_W +: NUM_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrNum    <= '0;
      wrData   <= '0;
      protFlag <= 1'b0;
    end else begin
      if (strobes.captureCmd) begin
        wrNum    <= byteData[NUM_W-1:0];
        protFlag <= |protHit;
      end
      if (strobes.shiftByte)
        wrData <= {wrData[DATA_W-BYTE_W-1:0], byteData};
    end
  end

  always_comb begin
    dbgByteEn = '1;
    if (protFlag) dbgByteEn[OPER_BYTES-1] = 1'b0;
  end

  // R3: register number stays fixed while operand bytes are taken
  p_num_stable_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftByte |=> $stable(wrNum));
endmodule

// File: rtl/dbgwr_decoder.sv
module dbgwr_decoder
  import dbgwr_pkg::*;
#(
  parameter int NUM_PROT = 3,
  parameter logic [NUM_PROT*NUM_W-1:0] PROT_NUMS = {6'h02, 6'h01, 6'h00}
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        coreHalted,
  output logic        cpuWrEn,
  output logic        dbgWrEn,
  output logic [5:0]  wrNum,
  output logic [31:0] wrData,
  output logic [3:0]  dbgByteEn,
  output logic        illegalCmd
);
  ctrlStrobes_t strobes;

  dbgwr_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .byteValid  (byteValid),
    .cmdTop     (byteData[7:6]),
    .coreHalted (coreHalted),
    .strobes    (strobes),
    .cpuWrEn    (cpuWrEn),
    .dbgWrEn    (dbgWrEn),
    .illegalCmd (illegalCmd)
  );

  dbgwr_dpath #(.NUM_PROT(NUM_PROT), .PROT_NUMS(PROT_NUMS)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .byteData  (byteData),
    .wrNum     (wrNum),
    .wrData    (wrData),
    .dbgByteEn (dbgByteEn)
  );
endmodule

// File: tb/tb_dbgwr_decoder.sv
module tb_dbgwr_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, byteValid = 1'b0, coreHalted = 1'b0;
  logic [7:0] byteData = '0;
  logic cpuWrEn, dbgWrEn, illegalCmd;
  logic [5:0] wrNum;
  logic [31:0] wrData;
  logic [3:0] dbgByteEn;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgwr_decoder dut (.*);

  typedef struct {
    int          kind;   // 1 cpu, 2 dbg, 3 illegal
    logic [5:0]  num;
    logic [31:0] data;
    logic [3:0]  be;
    string       req;
  } item_t;

  item_t expQ[$];
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops an expectation for every result pulse
  always @(negedge clk) begin
    if (!rst && (cpuWrEn || dbgWrEn || illegalCmd)) begin
      int k;
      k = cpuWrEn ? 1 : (dbgWrEn ? 2 : 3);
      if (expQ.size() == 0) begin
        check(1'b0, "R3", "unexpected pulse kind", 64'(k), 64'd0);
      end else begin
        item_t e;
        e = expQ.pop_front();
        check(k == e.kind, e.req, "kind", 64'(k), 64'(e.kind));
        if (e.kind != 3) begin
          check(wrNum == e.num, e.req, "wrNum", 64'(wrNum), 64'(e.num));
          check(wrData == e.data, e.req, "wrData", 64'(wrData), 64'(e.data));
        end
        if (e.kind == 2)
          check(dbgByteEn == e.be, e.req, "dbgByteEn", 64'(dbgByteEn), 64'(e.be));
      end
    end
  end

  task automatic putByte(input logic [7:0] b, input int gap);
    @(negedge clk);
    byteValid = 1'b1;
    byteData  = b;
    @(negedge clk);
    byteValid = 1'b0;
    byteData  = 8'hxx;
    repeat (gap) @(negedge clk);
  endtask

  function automatic bit isProt(input logic [5:0] n);
    return n == 6'h00 || n == 6'h01 || n == 6'h02;
  endfunction

  // driver: pushes the expectation, then drives command and operand
  task automatic sendCmd(input logic [7:0] cmd, input logic [31:0] data,
                         input logic halt, input logic haltLater,
                         input int gap, input string req);
    item_t e;
    e.num = cmd[5:0]; e.data = data; e.req = req;
    e.be = isProt(cmd[5:0]) ? 4'b0111 : 4'b1111;
    if (cmd[7:6] == 2'b11) begin e.kind = halt ? 1 : 3; expQ.push_back(e); end
    else if (cmd[7:6] == 2'b10) begin e.kind = 2; expQ.push_back(e); end
    coreHalted = halt;
    putByte(cmd, gap);
    if (cmd[7] == 1'b1) begin
      coreHalted = haltLater;
      for (int i = 3; i >= 0; i--) putByte(data[i*8 +: 8], gap);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!cpuWrEn && !dbgWrEn && !illegalCmd, "R9", "outputs in reset",
          64'({cpuWrEn, dbgWrEn, illegalCmd}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!cpuWrEn && !dbgWrEn && !illegalCmd, "R9", "outputs after reset",
          64'({cpuWrEn, dbgWrEn, illegalCmd}), 64'd0);

    sendCmd(8'hC5, 32'h1234_5678, 1, 1, 0, "R1_R2");
    sendCmd(8'hFF, 32'hA1B2_C3D4, 1, 1, 2, "R1_R3");
    sendCmd(8'hC3, 32'hDEAD_BEEF, 0, 0, 0, "R4");
    sendCmd(8'h90, 32'h0BAD_F00D, 0, 0, 0, "R6_R4 alignment");
    sendCmd(8'hA7, 32'hCAFE_0001, 1, 1, 1, "R6");
    sendCmd(8'h81, 32'hFFEE_DDCC, 0, 0, 0, "R7 protected");
    sendCmd(8'h80, 32'h1122_3344, 1, 1, 0, "R7 protected");
    sendCmd(8'h82, 32'h5566_7788, 0, 0, 0, "R7 protected");
    sendCmd(8'h83, 32'h99AA_BBCC, 0, 0, 0, "R7 unprotected");
    sendCmd(8'h3F, 32'h0, 0, 0, 0, "R8");
    sendCmd(8'h00, 32'h0, 0, 0, 0, "R8");
    sendCmd(8'hC9, 32'h0102_0304, 1, 1, 0, "R8 then R1");
    sendCmd(8'hCA, 32'h1357_9BDF, 1, 0, 0, "R5");
    sendCmd(8'hCB, 32'h2468_ACE0, 0, 1, 0, "R5");
    sendCmd(8'h8A, 32'h7777_8888, 1, 1, 0, "R5 alignment");

    // R9: reset in the middle of a command discards it
    coreHalted = 1'b1;
    putByte(8'hC7, 0);
    putByte(8'h11, 0);
    putByte(8'h22, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    sendCmd(8'hC8, 32'hFACE_B00C, 1, 1, 0, "R9 after abort");

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R3", "missing pulses", 64'(expQ.size()), 64'd0);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule